// File: doc/BRIEF.md
# Battery-Backed Static RAM Strobe Controller

This block sits between a synchronous host and an external asynchronous 32K x 8 static RAM that keeps its contents on a backup cell. The host issues one read or one write at a time over a valid/ready request port. The controller turns each request into a timed sequence on the memory's active-low chip-select, output-enable and write-strobe pins. Every phase is held for a whole number of clock cycles. Those counts come from nanosecond figures and a clock-period parameter, rounded up. Each request ends with a one-cycle response that carries the read byte and an error flag.

An external supply monitor drives a power-good input. This input is synchronous to the controller clock. While it is low, all strobes are forced inactive in the same cycle and no request is accepted. An access that is cut short by a power loss is answered with the error flag set. When power-good returns, the controller accepts nothing until power-good has stayed high for a recovery time of 15 µs. The same wait applies after reset.

Top module: `sram_nv_ctrl`

## Requirements
- R1: A byte written to an address is returned unchanged by a later read of that address, across the full 15-bit address range.
- R2: A read holds chip-select and output-enable low with write-strobe high for max(ceil(100 ns), ceil(50 ns)) cycles. The byte on `sram_dq_i` is captured at the clock edge that ends this phase.
- R3: A write holds chip-select and write-strobe low with output-enable high for max(ceil(60 ns), ceil(35 ns)) cycles. `sram_dq_oe_o` is high in exactly those cycles, and `sram_dq_o` carries the request's data.
- R4: After a write phase, all strobes stay high for max(ceil(100 ns) − write-phase cycles, 1) cycles before the response and before any new request is accepted.
- R5: After a read phase, all strobes stay high for ceil(35 ns) cycles before the response, so the bus is released before any later write drives it. `sram_dq_oe_o` is never high while output-enable is low.
- R6: `sram_addr_o` changes only while write-strobe is high, and it holds the request's address for the whole access.
- R7: Only one request is in flight. `req_ready_o` is high only when the controller is idle, and chip-select is high while idle. `rsp_valid_o` is a single-cycle pulse, raised one cycle after the final phase of an access.
- R8: In any cycle with `pwr_good_i` low, chip-select, output-enable and write-strobe are high, `sram_dq_oe_o` is low and `req_ready_o` is low, combinationally in that same cycle.
- R9: If `pwr_good_i` is low at a clock edge while a read or write phase is active, the access ends at that edge and the next cycle shows `rsp_valid_o` = 1 with `rsp_err_o` = 1. Accesses that complete normally respond with `rsp_err_o` = 0.
- R10: `req_ready_o` stays low until `pwr_good_i` has been sampled high on ceil(T_REC_NS) consecutive clock edges, counted from reset release or from the last low sample.
- R11: During and directly after reset, all strobes are high, `sram_dq_oe_o` is low, and `rsp_valid_o` and `req_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Access aborted by power loss |
| rsp_rdata_o | output | 8 | Read data, meaningful for reads |
| pwr_good_i | input | 1 | Supply monitor output, synchronous, high = supply above threshold |
| sram_ce_n_o | output | 1 | Memory chip-select, active low |
| sram_oe_n_o | output | 1 | Memory output-enable, active low |
| sram_we_n_o | output | 1 | Memory write-strobe, active low |
| sram_addr_o | output | 15 | Memory address |
| sram_dq_o | output | 8 | Data toward memory |
| sram_dq_oe_o | output | 1 | Drive enable for the data pads |
| sram_dq_i | input | 8 | Data from memory |

## Verification
The hardest case to reach is a supply loss landing inside an active strobe phase. The same event also hits the recovery wait that follows. The stimulus accepts a write and then a read, and lowers power-good a few cycles into each strobe phase. It checks that the strobes go inactive in that same cycle and that the error response follows. A request is left pending across the whole recovery window, so the exact cycle in which it is accepted is compared against a cycle-level reference model.

// File: rtl/sram_nv_pkg.sv
package sram_nv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_HZ,
    ST_WR,
    ST_WR_REC
  } seq_st_e;

  // nanoseconds -> cycles, rounded up, never zero
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_nv_pwr.sv
module sram_nv_pwr #(
  parameter int unsigned REC_CYC = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic pwr_ok_o
);
  localparam int unsigned CW = $clog2(REC_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!pwr_good_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!ok_q) begin
      if (cnt_q == CW'(REC_CYC - 1)) ok_q <= 1'b1;
      else                           cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwr_ok_o = ok_q;
endmodule

// File: rtl/sram_nv_seq.sv
module sram_nv_seq
  import sram_nv_pkg::*;
#(
  parameter int unsigned AW       = 15,
  parameter int unsigned DW       = 8,
  parameter int unsigned RD_CYC   = 10,
  parameter int unsigned HZ_CYC   = 4,
  parameter int unsigned WL_CYC   = 6,
  parameter int unsigned WREC_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_good_i,
  input  logic          pwr_ok_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_i
);
  localparam int unsigned MAXC = max2(max2(RD_CYC, HZ_CYC), max2(WL_CYC, WREC_CYC));
  localparam int unsigned CW   = $clog2(MAXC + 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q, lim;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_valid_q, rsp_err_q;
  logic          strobing, last, accept;

  always_comb begin
    case (st_q)
      ST_RD:     lim = CW'(RD_CYC - 1);
      ST_RD_HZ:  lim = CW'(HZ_CYC - 1);
      ST_WR:     lim = CW'(WL_CYC - 1);
      ST_WR_REC: lim = CW'(WREC_CYC - 1);
      default:   lim = '0;
    endcase
  end

  assign last     = (cnt_q == lim);
  assign strobing = (st_q == ST_RD) || (st_q == ST_WR);
  assign req_ready_o = (st_q == ST_IDLE) && pwr_ok_i && pwr_good_i;
  assign accept   = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (strobing && !pwr_good_i) begin
        // supply lost mid-access: abort and flag
        st_q        <= ST_IDLE;
        cnt_q       <= '0;
        rsp_valid_q <= 1'b1;
        rsp_err_q   <= 1'b1;
      end else begin
        case (st_q)
          ST_IDLE: if (accept) begin
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            cnt_q   <= '0;
            st_q    <= req_write_i ? ST_WR : ST_RD;
          end
          ST_RD: if (last) begin
            rdata_q <= dq_i;
            cnt_q   <= '0;
            st_q    <= ST_RD_HZ;
          end else cnt_q <= cnt_q + 1'b1;
          ST_WR: if (last) begin
            cnt_q <= '0;
            st_q  <= ST_WR_REC;
          end else cnt_q <= cnt_q + 1'b1;
          ST_RD_HZ, ST_WR_REC: if (last) begin
            cnt_q       <= '0;
            st_q        <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= 1'b0;
          end else cnt_q <= cnt_q + 1'b1;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ce_n_o  = !(strobing && pwr_good_i);
  assign oe_n_o  = !((st_q == ST_RD) && pwr_good_i);
  assign we_n_o  = !((st_q == ST_WR) && pwr_good_i);
  assign dq_oe_o = (st_q == ST_WR) && pwr_good_i;
  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/sram_nv_ctrl.sv
module sram_nv_ctrl
  import sram_nv_pkg::*;
#(
  parameter int unsigned AW            = 15,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_RC_NS       = 100,
  parameter int unsigned T_OE_NS       = 50,
  parameter int unsigned T_HZ_NS       = 35,
  parameter int unsigned T_WP_NS       = 60,
  parameter int unsigned T_DS_NS       = 35,
  parameter int unsigned T_WC_NS       = 100,
  parameter int unsigned T_REC_NS      = 15000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  input  logic          pwr_good_i,
  output logic          sram_ce_n_o,
  output logic          sram_oe_n_o,
  output logic          sram_we_n_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int unsigned RD_CYC   = max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_PS),
                                          ns_to_cyc(T_OE_NS, CLK_PERIOD_PS));
  localparam int unsigned HZ_CYC   = ns_to_cyc(T_HZ_NS, CLK_PERIOD_PS);
  localparam int unsigned WL_CYC   = max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_PS),
                                          ns_to_cyc(T_DS_NS, CLK_PERIOD_PS));
  localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, CLK_PERIOD_PS);
  localparam int unsigned WREC_CYC = (WC_CYC > WL_CYC + 1) ? WC_CYC - WL_CYC : 1;
  localparam int unsigned REC_CYC  = ns_to_cyc(T_REC_NS, CLK_PERIOD_PS);

  logic pwr_ok;

  sram_nv_pwr #(.REC_CYC(REC_CYC)) u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .pwr_ok_o   (pwr_ok)
  );

  sram_nv_seq #(
    .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC),
    .WL_CYC(WL_CYC), .WREC_CYC(WREC_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_good_i  (pwr_good_i),
    .pwr_ok_i    (pwr_ok),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o),
    .ce_n_o      (sram_ce_n_o),
    .oe_n_o      (sram_oe_n_o),
    .we_n_o      (sram_we_n_o),
    .addr_o      (sram_addr_o),
    .dq_o        (sram_dq_o),
    .dq_oe_o     (sram_dq_oe_o),
    .dq_i        (sram_dq_i)
  );
endmodule

// File: rtl/sram_nv_chk.sv
module sram_nv_chk #(
  parameter int unsigned AW      = 15,
  parameter int unsigned WL_CYC  = 6,
  parameter int unsigned REC_CYC = 1500
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwr_good_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          sram_ce_n_o,
  input logic          sram_oe_n_o,
  input logic          sram_we_n_o,
  input logic [AW-1:0] sram_addr_o,
  input logic          sram_dq_oe_o
);
  localparam int unsigned PW = $clog2(REC_CYC + 1);

  logic [PW-1:0] pg_cnt;
  logic [15:0]   wl_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_cnt <= '0;
      wl_cnt <= '0;
    end else begin
      if (!pwr_good_i)                    pg_cnt <= '0;
      else if (pg_cnt != PW'(REC_CYC))    pg_cnt <= pg_cnt + 1'b1;
      if (sram_we_n_o)                    wl_cnt <= '0;
      else if (wl_cnt != 16'hffff)        wl_cnt <= wl_cnt + 1'b1;
    end
  end

  a_r8_pf_forces_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> (sram_ce_n_o && sram_oe_n_o && sram_we_n_o && !sram_dq_oe_o && !req_ready_o));

  a_r3_drive_only_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (!sram_we_n_o && !sram_ce_n_o && sram_oe_n_o));

  a_r3_we_pulse_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sram_we_n_o) && pwr_good_i) |-> (wl_cnt >= 16'(WL_CYC)));

  a_r5_no_drive_while_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> !sram_dq_oe_o);

  a_r2_no_oe_we_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_n_o && !sram_we_n_o));

  a_r6_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_n_o && $past(!sram_we_n_o)) |-> $stable(sram_addr_o));

  a_r7_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r7_idle_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> sram_ce_n_o);

  a_r10_ready_after_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (pg_cnt >= PW'(REC_CYC)));
endmodule

bind sram_nv_ctrl sram_nv_chk #(
  .AW(AW), .WL_CYC(WL_CYC), .REC_CYC(REC_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_good_i   (pwr_good_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_ce_n_o  (sram_ce_n_o),
  .sram_oe_n_o  (sram_oe_n_o),
  .sram_we_n_o  (sram_we_n_o),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_nv_ctrl_bench.sv
module sram_nv_ctrl_bench;
  localparam int PER_PS = 8000;
  localparam int REC_NS = 1000;

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RDC  = imax(cdiv(100000, PER_PS), cdiv(50000, PER_PS));
  localparam int HZ   = cdiv(35000, PER_PS);
  localparam int WL   = imax(cdiv(60000, PER_PS), cdiv(35000, PER_PS));
  localparam int WREC = imax(cdiv(100000, PER_PS) - WL, 1);
  localparam int REC  = cdiv(REC_NS * 1000, PER_PS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, pg = 1'b1;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [7:0] rsp_rdata;
  logic ce_n, oe_n, we_n, dq_oe;
  logic [14:0] sa;
  logic [7:0] dq_o, dq_i;

  always #4 clk = ~clk;

  sram_nv_ctrl #(.CLK_PERIOD_PS(PER_PS), .T_REC_NS(REC_NS)) u_sram_nv_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .pwr_good_i(pg),
    .sram_ce_n_o(ce_n), .sram_oe_n_o(oe_n), .sram_we_n_o(we_n),
    .sram_addr_o(sa), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // external memory model
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  function automatic logic [7:0] rd_mem(logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction
  assign dq_i = (!ce_n && !oe_n && we_n) ? rd_mem(sa) : 8'h00;
  always @(posedge clk) if (rst_n && !ce_n && !we_n && dq_oe) mem[int'(sa)] = dq_o;

  int nchk = 0, nerr = 0;
  bit done = 0;
  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // cycle reference model: 0 idle, 1 read, 2 read release, 3 write, 4 write recovery
  int ph = 0, left = 0, okc = 0;
  bit m_rsp = 0, m_err = 0, m_rdy = 0;
  logic [14:0] m_addr = '0;
  logic [7:0]  m_wd = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; left = 0; okc = 0; m_rsp = 0; m_err = 0;
    end else begin
      m_rdy = (ph == 0) && (okc >= REC) && pg;
      m_rsp = 0;
      if ((ph == 1 || ph == 3) && !pg) begin
        ph = 0; m_rsp = 1; m_err = 1;
      end else begin
        case (ph)
          0: if (m_rdy && req_valid) begin
               m_addr = req_addr; m_wd = req_wdata;
               ph = req_write ? 3 : 1; left = req_write ? WL : RDC;
             end
          1: begin left--; if (left == 0) begin ph = 2; left = HZ; end end
          3: begin left--; if (left == 0) begin ph = 4; left = WREC; end end
          default: begin left--; if (left == 0) begin ph = 0; m_rsp = 1; m_err = 0; end end
        endcase
      end
      if (!pg) okc = 0; else if (okc < REC) okc++;
    end
  end

  function automatic string stb_tag();
    if (!pg) return "R8";
    if (ph == 1) return "R2";
    if (ph == 3) return "R3";
    if (ph == 2) return "R5";
    if (ph == 4) return "R4";
    return "R7";
  endfunction

  initial forever begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      chk(ce_n  === !((ph == 1 || ph == 3) && pg), stb_tag(), "ce_n", ce_n, !((ph == 1 || ph == 3) && pg));
      chk(oe_n  === !(ph == 1 && pg), stb_tag(), "oe_n", oe_n, !(ph == 1 && pg));
      chk(we_n  === !(ph == 3 && pg), stb_tag(), "we_n", we_n, !(ph == 3 && pg));
      chk(dq_oe === (ph == 3 && pg), "R3", "dq_oe", dq_oe, (ph == 3 && pg));
      chk(req_ready === ((ph == 0) && (okc >= REC) && pg), "R10", "req_ready",
          req_ready, (ph == 0) && (okc >= REC) && pg);
      chk(rsp_valid === m_rsp, "R7", "rsp_valid", rsp_valid, m_rsp);
      if (m_rsp) chk(rsp_err === m_err, "R9", "rsp_err", rsp_err, m_err);
      if (!ce_n) chk(sa === m_addr, "R6", "addr", sa, m_addr);
      if (dq_oe) chk(dq_o === m_wd, "R3", "dq_o", dq_o, m_wd);
    end
  end

  // issue one request, wait for its response
  task automatic xfer(bit wr, logic [14:0] a, logic [7:0] d, output logic [7:0] rd, output bit err);
    int n;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    n = 0;
    #1;
    while (!req_ready && n < 5000) begin @(negedge clk); #1; n++; end
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    #1;
    while (!rsp_valid && n < 200) begin @(negedge clk); #1; n++; end
    rd = rsp_rdata; err = rsp_err;
  endtask

  task automatic do_write(logic [14:0] a, logic [7:0] d);
    logic [7:0] rd; bit err;
    xfer(1'b1, a, d, rd, err);
    chk(err == 1'b0, "R9", "write err", err, 0);
    shadow[int'(a)] = d;
  endtask

  task automatic do_read(logic [14:0] a);
    logic [7:0] rd; bit err;
    xfer(1'b0, a, 8'h00, rd, err);
    chk(err == 1'b0, "R9", "read err", err, 0);
    chk(rd === shadow[int'(a)], "R1", "read data", rd, shadow[int'(a)]);
  endtask

  // start an access, drop power a few cycles into its strobe phase
  task automatic abort_access(bit wr, logic [14:0] a, logic [7:0] d);
    int n;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    n = 0;
    #1;
    while (!req_ready && n < 5000) begin @(negedge clk); #1; n++; end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    pg = 1'b0;
    #1;
    chk(ce_n && oe_n && we_n && !dq_oe, "R8", "strobes on power fail", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
    chk(!req_ready, "R8", "ready on power fail", req_ready, 0);
    @(negedge clk); #1;
    chk(rsp_valid && rsp_err, "R9", "abort response", {rsp_valid, rsp_err}, 2'b11);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    #1;
    chk(ce_n && oe_n && we_n && !dq_oe, "R11", "reset strobes", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
    chk(!rsp_valid && !req_ready, "R11", "reset handshake", {rsp_valid, req_ready}, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!req_ready && ce_n, "R11", "after reset", {req_ready, ce_n}, 1);
    t = 0;
    while (!req_ready && t < 5000) begin @(negedge clk); #1; t++; end
    chk(t == REC, "R10", "cycles to ready after reset", t, REC);

    do_write(15'h0000, 8'h5a);
    do_write(15'h7fff, 8'ha5);
    do_write(15'h1234, 8'hff);
    do_write(15'h2aaa, 8'h00);
    do_read(15'h7fff);
    do_read(15'h0000);
    do_write(15'h0001, 8'h3c);   // write right after a read (R5 turnaround)
    do_read(15'h1234);
    do_read(15'h2aaa);
    do_read(15'h0001);
    do_write(15'h1234, 8'h81);   // overwrite
    do_read(15'h1234);

    // power loss during a write phase
    abort_access(1'b1, 15'h0100, 8'h77);
    req_write = 1'b0; req_addr = 15'h7fff; req_valid = 1'b1;
    repeat (10) @(negedge clk);
    pg = 1'b1;
    t = 0;
    #1;
    while (!req_ready && t < 5000) begin @(negedge clk); #1; t++; end
    chk(t == REC, "R10", "cycles to ready after power return", t, REC);
    @(negedge clk); req_valid = 1'b0;
    t = 0;
    #1;
    while (!rsp_valid && t < 200) begin @(negedge clk); #1; t++; end
    chk(rsp_rdata === shadow[32'h7fff], "R1", "read after recovery", rsp_rdata, shadow[32'h7fff]);

    // power loss during a read phase
    abort_access(1'b0, 15'h0000, 8'h00);
    repeat (4) @(negedge clk);
    pg = 1'b1;
    do_read(15'h0000);

    // short glitch while idle restarts the recovery wait
    @(negedge clk); pg = 1'b0;
    @(negedge clk); pg = 1'b1;
    t = 0;
    #1;
    while (!req_ready && t < 5000) begin @(negedge clk); #1; t++; end
    chk(t == REC, "R10", "recovery after idle glitch", t, REC);
    do_write(15'h4321, 8'hc3);
    do_read(15'h4321);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule